// File: doc/BRIEF.md
# Window-Deferred Request Acknowledger

This block sits between a requester and a processing engine. The engine brackets each job with a start pulse and a closing end-of-job pulse. The requester issues single-cycle requests and receives single-cycle acknowledges. A request that arrives while no job is open is acknowledged on the next clock. A request that arrives while a job is open is held back. Its acknowledge is released a programmable number of cycles after the end-of-job pulse closes the job.

The time between start and end-of-job is unbounded and varies at run time, so the block never counts the job length. It tracks the job as an open/closed window. Each window carries a single pending flag. After the window closes, a small down-counter times the release. The release delay comes from a 4-bit input that is clamped into the legal range of 1 to 10 cycles.

Top module: `deferred_ack`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `ack` low, no open window and nothing pending. This holds whatever `start`, `eop` and `req` do during reset.
- R2: A rising edge of `start` (high now, low in the previous cycle) opens a window from the following cycle. A start edge while a window is already open is ignored and does not clear the pending request.
- R3: A request in a cycle with no open window is acknowledged in the next cycle. This includes a request in the same cycle as the opening start edge.
- R4: For a request made while a window is open, `ack` stays low from the request through the cycle in which `eop` closes that window.
- R5: A held acknowledge is asserted exactly D cycles after the closing `eop` cycle, where D is the clamped delay sampled in the `eop` cycle.
- R6: The delay input is clamped as follows: 0 gives D = 1, values 1 to 10 are used as given, and 11 to 15 give D = 10.
- R7: Several requests inside one window merge into one pending request and produce exactly one acknowledge.
- R8: An `eop` while no window is open has no effect. A window that closes with no request in it produces no acknowledge.
- R9: A request in the same cycle as the closing `eop` counts as inside the window and is released after D cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Job start; its rising edge opens a window |
| eop | input | 1 | Single-cycle end-of-job pulse that closes the open window |
| req | input | 1 | Single-cycle request |
| rel_dly | input | DLY_W | Requested release delay after `eop`, clamped to DLY_MIN..DLY_MAX |
| ack | output | 1 | Single-cycle acknowledge |

## Verification
The bench builds the block with its default parameters: a 4-bit delay input and limits of 1 and 10. With these settings the full input range is reachable, including 0 and the values 11 to 15 that must be clamped. Both ends of the delay range (1 and 10 cycles after `eop`) are timed exactly. Windows of different lengths are combined with requests on the start edge, in the middle, several at once, on the closing `eop`, and not at all. A second start edge is placed inside an open window, and a stray `eop` arrives with no window open.

// File: rtl/dack_pkg.sv
package dack_pkg;

    typedef enum logic {
        WIN_IDLE = 1'b0,
        WIN_OPEN = 1'b1
    } win_state_t;

    typedef struct packed {
        win_state_t state;
        logic       pend;
        logic       start_q;
    } win_reg_t;

    localparam win_reg_t WIN_RESET = '{state: WIN_IDLE, pend: 1'b0, start_q: 1'b0};

    function automatic int unsigned clamp_range(input int unsigned v,
                                                input int unsigned lo,
                                                input int unsigned hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/dack_window.sv
module dack_window
    import dack_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic eop,
    input  logic req,
    output logic win_open,
    output logic pend,
    output logic rise,
    output logic imm,
    output logic release_evt
);
    win_reg_t cur, nxt;
    logic     close;

    assign win_open    = (cur.state == WIN_OPEN);
    assign pend        = cur.pend;
    assign rise        = start & ~cur.start_q;
    assign close       = win_open & eop;
    assign imm         = req & ~win_open;
    assign release_evt = close & (cur.pend | req);

    always_comb begin
        nxt         = cur;
        nxt.start_q = start;
        unique case (cur.state)
            WIN_IDLE: begin
                if (rise) begin
                    nxt.state = WIN_OPEN;
                    nxt.pend  = 1'b0;
                end
            end
            WIN_OPEN: begin
                if (eop) begin
                    nxt.state = WIN_IDLE;
                    nxt.pend  = 1'b0;
                end else if (req) begin
                    nxt.pend  = 1'b1;
                end
            end
            default: nxt = WIN_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= WIN_RESET;
        else     cur <= nxt;
    end
endmodule

// File: rtl/dack_release.sv
module dack_release #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] dly,
    output logic          fire
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt;

    assign fire = (load && dly == ONE) || (cnt == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (dly == ONE) ? '0 : dly - ONE;
        end else if (cnt != '0) begin
            cnt <= cnt - ONE;
        end
    end
endmodule

// File: rtl/deferred_ack.sv
module deferred_ack
    import dack_pkg::*;
#(
    parameter int DLY_W   = 4,
    parameter int DLY_MIN = 1,
    parameter int DLY_MAX = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             eop,
    input  logic             req,
    input  logic [DLY_W-1:0] rel_dly,
    output logic             ack
);
    localparam int unsigned LO = (DLY_MIN < 1) ? 1 : DLY_MIN;
    localparam int unsigned HI = (DLY_MAX < LO) ? LO : DLY_MAX;

    logic             win_open, pend, rise, imm, load, fire;
    logic [DLY_W-1:0] dly_eff;
    logic             ack_q;

    always_comb dly_eff = DLY_W'(clamp_range(int'(rel_dly), LO, HI));

    dack_window u_win (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .eop         (eop),
        .req         (req),
        .win_open    (win_open),
        .pend        (pend),
        .rise        (rise),
        .imm         (imm),
        .release_evt (load)
    );

    dack_release #(.CW(DLY_W)) u_rel (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .dly  (dly_eff),
        .fire (fire)
    );

    always_ff @(posedge clk) begin
        if (rst) ack_q <= 1'b0;
        else     ack_q <= imm | fire;
    end

    assign ack = ack_q;
endmodule

// File: rtl/dack_checker.sv
module dack_checker #(
    parameter int DLY_W   = 4,
    parameter int DLY_MIN = 1,
    parameter int DLY_MAX = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             eop,
    input logic             req,
    input logic             ack,
    input logic             win_open,
    input logic             pend,
    input logic             rise,
    input logic             load,
    input logic             fire,
    input logic [DLY_W-1:0] dly_eff
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!ack && !win_open && !pend)); // R1

    AST_EDGE_OPENS: assert property (@(posedge clk) disable iff (rst)
        (rise && !win_open) |=> win_open); // R2

    AST_REOPEN_KEEPS_PEND: assert property (@(posedge clk) disable iff (rst)
        (win_open && pend && start && !eop) |=> pend); // R2

    AST_IDLE_REQ_ACKED: assert property (@(posedge clk) disable iff (rst)
        (req && !win_open) |=> ack); // R3

    AST_HELD_QUIET: assert property (@(posedge clk) disable iff (rst)
        (pend && !$past(fire)) |-> !ack); // R4

    AST_SHORT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (load && dly_eff == DLY_W'(1)) |=> ack); // R5

    AST_DELAY_CLAMPED: assert property (@(posedge clk) disable iff (rst)
        load |-> (int'(dly_eff) >= DLY_MIN && int'(dly_eff) <= DLY_MAX)); // R6

    AST_STRAY_EOP: assert property (@(posedge clk) disable iff (rst)
        (eop && !win_open && !start) |=> !win_open); // R8

    AST_EMPTY_CLOSE: assert property (@(posedge clk) disable iff (rst)
        (win_open && eop && !pend && !req) |-> !load); // R8
endmodule

bind deferred_ack dack_checker #(
    .DLY_W   (DLY_W),
    .DLY_MIN (DLY_MIN),
    .DLY_MAX (DLY_MAX)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .eop      (eop),
    .req      (req),
    .ack      (ack),
    .win_open (win_open),
    .pend     (pend),
    .rise     (rise),
    .load     (load),
    .fire     (fire),
    .dly_eff  (dly_eff)
);

// File: tb/deferred_ack_tb.sv
`timescale 1ns/1ps
module deferred_ack_tb;
    typedef struct {
        int    cyc;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0, eop = 1'b0, req = 1'b0;
    logic [3:0] rel_dly = 4'd1;
    logic       ack;

    int   cyc = 0;
    int   n_cmp = 0, n_bad = 0;
    bit   armed = 1'b0;
    bit   done = 1'b0;
    exp_t q[$];

    deferred_ack u_dut (
        .clk(clk), .rst(rst), .start(start), .eop(eop),
        .req(req), .rel_dly(rel_dly), .ack(ack)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int eff(input int v);
        if (v < 1)  return 1;
        if (v > 10) return 10;
        return v;
    endfunction

    task automatic expect_at(input int c, input string tag);
        exp_t e;
        e.cyc = c;
        e.tag = tag;
        q.push_back(e);
    endtask

    // Scoreboard monitor: compares ack against the queued expectations every cycle.
    always @(negedge clk) begin
        if (armed) begin
            bit    want;
            string tag;
            tag = "R4";
            while (q.size() > 0 && q[0].cyc < cyc) begin
                n_cmp++; n_bad++;
                $display("FAIL %s: missed ack at cycle %0d, actual 0 expected 1", q[0].tag, q[0].cyc);
                void'(q.pop_front());
            end
            want = (q.size() > 0 && q[0].cyc == cyc);
            if (want) begin
                tag = q[0].tag;
                void'(q.pop_front());
            end
            n_cmp++;
            if (ack !== want) begin
                n_bad++;
                $display("FAIL %s: cycle %0d ack actual %b expected %b", tag, cyc, ack, want);
            end
        end
    end

    task automatic step(input logic s, input logic e, input logic r);
        start = s; eop = e; req = r;
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0);
    endtask

    // Window: start at k=0, eop at k=len; requests at k=ra and k=rb (-1 for none).
    task automatic run_window(input int len, input int ra, input int rb,
                              input int d, input string tag);
        int  s0;
        bit  held;
        held = 1'b0;
        rel_dly = 4'(d);
        s0 = cyc;
        for (int k = 0; k <= len; k++) begin
            bit r;
            r = (k == ra) || (k == rb);
            if (r && k == 0) expect_at(s0 + 1, "R3");
            if (r && k > 0) held = 1'b1;
            if (k == len && held) expect_at(s0 + len + eff(d), tag);
            step(k == 0, k == len, r);
        end
        idle(14);
    endtask

    initial begin
        // R1: reset with busy inputs
        step(1'b1, 1'b0, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        step(1'b1, 1'b0, 1'b1);
        #2;
        n_cmp++;
        if (ack !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: ack during reset actual %b expected 0", ack);
        end
        @(posedge clk); #1;
        start = 0; eop = 0; req = 0;
        rst = 1'b0;
        armed = 1'b1;
        idle(3);

        // R3: idle requests, single and back-to-back
        expect_at(cyc + 1, "R3"); step(0, 0, 1); idle(3);
        expect_at(cyc + 1, "R3"); step(0, 0, 1);
        expect_at(cyc + 1, "R3"); step(0, 0, 1);
        expect_at(cyc + 1, "R3"); step(0, 0, 1);
        idle(4);

        // R4 R5: held request, delay 1
        run_window(5, 2, -1, 1, "R5");
        // R5: delay 10, the top of the range
        run_window(4, 1, -1, 10, "R5");
        // R5: middle delay, long window
        run_window(20, 7, -1, 4, "R5");
        // R3 R8: request on the start edge only, window closes empty
        run_window(6, 0, -1, 3, "R3");
        // R6: delay 0 clamps to 1
        run_window(3, 1, -1, 0, "R6");
        // R6: delay 15 clamps to 10
        run_window(3, 2, -1, 15, "R6");
        // R6: delay 11 clamps to 10
        run_window(2, 1, -1, 11, "R6");
        // R7: many requests merge into one ack
        run_window(8, 1, 5, 2, "R7");
        // R9: request on the closing eop
        run_window(4, 4, -1, 3, "R9");
        // R8: window with no request
        run_window(5, -1, -1, 2, "R8");

        // R8: stray eop with no window, then idle request still immediate
        step(0, 1, 0); idle(3);
        expect_at(cyc + 1, "R8"); step(0, 0, 1); idle(4);

        // R2: second start edge inside an open window does not restart it
        begin
            int s0;
            rel_dly = 4'd1;
            s0 = cyc;
            step(1, 0, 0);            // k0 open
            step(0, 0, 0);            // k1
            step(0, 0, 1);            // k2 held
            step(0, 0, 0);            // k3
            step(1, 0, 0);            // k4 ignored edge
            step(0, 0, 0);            // k5
            expect_at(s0 + 7, "R2");
            step(0, 1, 0);            // k6 close
            expect_at(s0 + 9, "R2");
            step(0, 0, 0);            // k7 held ack appears
            step(0, 0, 1);            // k8 window closed -> immediate
            idle(6);
        end

        idle(4);
        if (q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R5: %0d expected acks never seen, actual 0 expected %0d", q.size(), q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R1: watchdog expired, actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule